// File: doc/BRIEF.md
# Column-Truncated Fractional Multiplier

This block multiplies two unsigned fractions in [0,1) and returns only the upper bits of the product. The lowest `CUT_COLS` columns of the partial-product array are never built. Every partial-product bit that would sit in those columns is left out, so the logic and adder cells that would serve them are gone too. The next `DROP_COLS` columns are built and summed, which lets their carries reach the kept part. Their own bits are then thrown away. The result has `A_W + B_W - CUT_COLS - DROP_COLS` bits and is aligned to the weight of the lowest kept column.

Because bits are left out and never rounded back in, the result can only be low. The error is one-sided and has a known bound. It is zero when every omitted bit and every dropped sum bit is zero. It is largest when all of them are one. The error is counted in units of the least significant bit of the full-width exact product.

The reduced rows pass through a carry-save chain. A final carry-propagate adder then sums them, and that adder spans only the formed columns. A parameter chooses one of two output modes. In the first, the output is driven straight from the adder. In the second, it is held in a register that loads on cycles where the input is flagged valid, and a matching valid flag follows one cycle later.

Top module: `trunc_mult`

## Requirements
- R1: With `CUT_COLS=0` and `DROP_COLS=0`, `product` equals the exact product `opA*opB`, bit for bit, over all operand pairs.
- R2: For every operand pair, the error `opA*opB - product*2^(CUT_COLS+DROP_COLS)` is never negative.
- R3: For every operand pair, that error is at most `S + (2^DROP_COLS - 1)*2^CUT_COLS`. Here S is the sum of `2^(i+j)` over every bit pair (operand-A bit j, operand-B bit i) whose column i+j is below `CUT_COLS`.
- R4: When no partial-product bit lies below column `CUT_COLS` (for example, when `opA` is a multiple of `2^CUT_COLS`), `product` equals `floor(opA*opB / 2^(CUT_COLS+DROP_COLS))`.
- R5: `product` equals `floor(F / 2^DROP_COLS)`. Here F is the sum of `2^(i+j-CUT_COLS)` over every set bit pair with column i+j at or above `CUT_COLS`.
- R6: With `REG_OUT=1`, `product` takes the new result one clock after a cycle with `inValid=1`, and `outValid` is high in that cycle. After a cycle with `inValid=0`, `outValid` is low and `product` holds its previous value.
- R7: With `REG_OUT=1`, while `rstN` is low, `outValid` and `product` are zero.
- R8: With `REG_OUT=0`, `product` follows the operands without waiting for a clock, and `outValid` equals `inValid`.
- R9: A zero operand gives a zero `product`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks the operands as a request; loads the register in registered mode |
| opA | input | A_W | Multiplicand, unsigned fraction |
| opB | input | B_W | Multiplier, unsigned fraction |
| outValid | output | 1 | Marks `product` as holding a fresh result |
| product | output | A_W+B_W-CUT_COLS-DROP_COLS | Truncated product, aligned to the lowest kept column |

## Verification
The bench builds three copies of the block, each small enough to cover every operand pair.

The first is a registered 6x6 unit that omits four columns and drops two. Walking every pair through it exercises the load, hold and valid timing, and checks the bit-exact column model and both error bounds. A short table of operands with no low partial-product bits pins the result to a plain floor division.

The second is a 5x5 combinational unit with no columns cut and none dropped. It must match the exact product on every pair.

The third is a combinational 7x4 unit with unequal operand widths, an odd cut and one dropped column. It reaches bit pairs, and column counts below the cut, that the square shapes miss.

// File: rtl/tmul_pkg.sv
package tmul_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic capture;   // load the output register this cycle
  } tmulStrobes_t;

  // Largest total weight of the partial-product bits that sit below
  // column cutCols, in units of the full product LSB.
  function automatic longint omitMax(input int aw, input int bw, input int cutCols);
    longint acc;
    acc = 0;
    for (int i = 0; i < bw; i++) begin
      for (int j = 0; j < aw; j++) begin
        if (i + j < cutCols) acc = acc + (longint'(1) << (i + j));
      end
    end
    return acc;
  endfunction

endpackage

// File: rtl/tmul_ppgen.sv
// Builds only the partial-product bits at or above column CUT.
// Row i, bit t stands for column t+CUT.
module tmul_ppgen #(
  parameter int A_W    = 8,
  parameter int B_W    = 8,
  parameter int CUT    = 4,
  parameter int FORM_W = A_W + B_W - CUT
) (
  input  logic [A_W-1:0]             opA,
  input  logic [B_W-1:0]             opB,
  output logic [B_W-1:0][FORM_W-1:0] rows
);

  for (genvar gi = 0; gi < B_W; gi++) begin : g_row
    for (genvar gt = 0; gt < FORM_W; gt++) begin : g_col
      localparam int COL = gt + CUT;
      localparam int IDX = COL - gi;
      if (IDX >= 0 && IDX < A_W) begin : g_bit
        assign rows[gi][gt] = opA[IDX] & opB[gi];
      end else begin : g_none
        assign rows[gi][gt] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/tmul_csa.sv
// Carry-save chain that folds the formed rows into two vectors.
// Wrapping at W bits is safe: the formed sum is below 2^W.
module tmul_csa #(
  parameter int ROWS = 8,
  parameter int W    = 12
) (
  input  logic [ROWS-1:0][W-1:0] rows,
  output logic [W-1:0]           sumV,
  output logic [W-1:0]           carryV
);

  logic [W-1:0] sAcc [ROWS];
  logic [W-1:0] cAcc [ROWS];

  assign sAcc[0] = rows[0];
  assign cAcc[0] = '0;

  for (genvar gi = 1; gi < ROWS; gi++) begin : g_stage
    logic [W-1:0] majV;
    assign sAcc[gi] = sAcc[gi-1] ^ cAcc[gi-1] ^ rows[gi];
    assign majV     = (sAcc[gi-1] & cAcc[gi-1]) | (sAcc[gi-1] & rows[gi]) |
                      (cAcc[gi-1] & rows[gi]);
    assign cAcc[gi] = {majV[W-2:0], 1'b0};
  end

  assign sumV   = sAcc[ROWS-1];
  assign carryV = cAcc[ROWS-1];

endmodule

// File: rtl/tmul_cpa.sv
// Shortened carry-propagate adder over the formed columns only.
module tmul_cpa #(
  parameter int W    = 12,
  parameter int DROP = 2
) (
  input  logic [W-1:0]      sumV,
  input  logic [W-1:0]      carryV,
  output logic [W-1:0]      formed,
  output logic [W-DROP-1:0] kept
);

  assign formed = sumV + carryV;
  assign kept   = formed[W-1:DROP];

endmodule

// File: rtl/tmul_ctrl.sv
module tmul_ctrl
  import tmul_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output tmulStrobes_t strobes,
  output logic         outValid
);

  assign strobes.capture = inValid;

  if (REG_OUT) begin : g_reg
    logic validQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ <= 1'b0;
      else       validQ <= inValid;
    end
    assign outValid = validQ;

    // R6: a request is flagged one cycle later
    p_valid_next_r6: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);
    // R6: an idle cycle clears the flag
    p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid);
    // R7: flag is low while reset is applied
    p_reset_flag_r7: assert property (@(posedge clk)
      !rstN |-> !outValid);
  end else begin : g_comb
    assign outValid = inValid;
  end

endmodule

// File: rtl/tmul_datapath.sv
module tmul_datapath
  import tmul_pkg::*;
#(
  parameter int A_W     = 8,
  parameter int B_W     = 8,
  parameter int CUT     = 4,
  parameter int DROP    = 2,
  parameter bit REG_OUT = 1'b1,
  localparam int PROD_W = A_W + B_W,
  localparam int FORM_W = PROD_W - CUT,
  localparam int OUT_W  = FORM_W - DROP
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmulStrobes_t     strobes,
  input  logic [A_W-1:0]   opA,
  input  logic [B_W-1:0]   opB,
  output logic [OUT_W-1:0] product
);

  localparam longint OMIT_MAX = omitMax(A_W, B_W, CUT);

  logic [B_W-1:0][FORM_W-1:0] rows;
  logic [FORM_W-1:0]          sumV;
  logic [FORM_W-1:0]          carryV;
  logic [FORM_W-1:0]          formed;
  logic [OUT_W-1:0]           kept;

  tmul_ppgen #(.A_W(A_W), .B_W(B_W), .CUT(CUT), .FORM_W(FORM_W)) u_ppgen (
    .opA  (opA),
    .opB  (opB),
    .rows (rows)
  );

  tmul_csa #(.ROWS(B_W), .W(FORM_W)) u_csa (
    .rows   (rows),
    .sumV   (sumV),
    .carryV (carryV)
  );

  tmul_cpa #(.W(FORM_W), .DROP(DROP)) u_cpa (
    .sumV   (sumV),
    .carryV (carryV),
    .formed (formed),
    .kept   (kept)
  );

  if (REG_OUT) begin : g_reg
    logic [OUT_W-1:0] productQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                productQ <= '0;
      else if (strobes.capture) productQ <= kept;
    end
    assign product = productQ;

    // R6: the register holds when no load strobe came
    p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.capture |=> $stable(productQ));
    // R7: cleared while reset is applied
    p_reset_zero_r7: assert property (@(posedge clk)
      !rstN |-> (productQ == '0));
  end else begin : g_comb
    assign product = kept;
  end

  // Checking aids: exact product and formed sum scaled to full weight.
  logic [PROD_W-1:0] exactChk;
  logic [PROD_W-1:0] formedScaled;
  assign exactChk     = PROD_W'(opA) * PROD_W'(opB);
  assign formedScaled = PROD_W'(formed) << CUT;

  // R2: leaving columns out can only make the sum smaller
  p_nonneg_r2: assert property (@(posedge clk) disable iff (!rstN)
    formedScaled <= exactChk);
  // R3: the shortfall of the formed sum stays within the omitted weight
  p_omit_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (exactChk - formedScaled) <= PROD_W'(OMIT_MAX));
  // R9: a zero operand reaches the adder as zero
  p_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opA == '0 || opB == '0) |-> (kept == '0));

endmodule

// File: rtl/trunc_mult.sv
module trunc_mult
  import tmul_pkg::*;
#(
  parameter int A_W       = 8,
  parameter int B_W       = 8,
  parameter int CUT_COLS  = 4,
  parameter int DROP_COLS = 2,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      inValid,
  input  logic [A_W-1:0]                            opA,
  input  logic [B_W-1:0]                            opB,
  output logic                                      outValid,
  output logic [A_W+B_W-CUT_COLS-DROP_COLS-1:0]     product
);

  tmulStrobes_t strobes;

  tmul_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  tmul_datapath #(
    .A_W     (A_W),
    .B_W     (B_W),
    .CUT     (CUT_COLS),
    .DROP    (DROP_COLS),
    .REG_OUT (REG_OUT)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .product (product)
  );

endmodule

// File: tb/trunc_mult_tb.sv
module trunc_mult_tb;

  localparam int CLK_PERIOD = 10;

  int total = 0;
  int bad   = 0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Registered unit: 6x6, cut 4, drop 2 -> 6 bit result
  logic       inValid = 1'b0;
  logic [5:0] dA = '0, dB = '0;
  logic       dValid;
  logic [5:0] dProd;
  trunc_mult #(.A_W(6), .B_W(6), .CUT_COLS(4), .DROP_COLS(2), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(dA), .opB(dB),
    .outValid(dValid), .product(dProd));

  // Exact combinational unit: 5x5, no cut, no drop
  logic       eValidIn = 1'b0;
  logic [4:0] eA = '0, eB = '0;
  logic       eValid;
  logic [9:0] eProd;
  trunc_mult #(.A_W(5), .B_W(5), .CUT_COLS(0), .DROP_COLS(0), .REG_OUT(1'b0)) u_exact (
    .clk(clk), .rstN(rstN), .inValid(eValidIn), .opA(eA), .opB(eB),
    .outValid(eValid), .product(eProd));

  // Skewed combinational unit: 7x4, cut 3, drop 1 -> 7 bit result
  logic       sValidIn = 1'b0;
  logic [6:0] sA = '0;
  logic [3:0] sB = '0;
  logic       sValid;
  logic [6:0] sProd;
  trunc_mult #(.A_W(7), .B_W(4), .CUT_COLS(3), .DROP_COLS(1), .REG_OUT(1'b0)) u_skew (
    .clk(clk), .rstN(rstN), .inValid(sValidIn), .opA(sA), .opB(sB),
    .outValid(sValid), .product(sProd));

  // R4 table: operands with no partial-product bit below column 4
  localparam int NVEC = 6;
  localparam logic [5:0] TAB_A [NVEC] = '{6'd0,  6'd16, 6'd48, 6'd63, 6'd63, 6'd32};
  localparam logic [5:0] TAB_B [NVEC] = '{6'd0,  6'd63, 6'd63, 6'd32, 6'd0,  6'd32};
  localparam logic [5:0] TAB_E [NVEC] = '{6'd0,  6'd15, 6'd47, 6'd31, 6'd0,  6'd16};

  // Reference: weight of set bit pairs at or above the cut, then drop.
  function automatic longint refTrunc(input longint a, input longint b,
                                      input int aw, input int bw,
                                      input int cutC, input int dropC);
    longint f = 0;
    for (int i = 0; i < bw; i++)
      for (int j = 0; j < aw; j++)
        if (a[j] && b[i] && (i + j >= cutC)) f += longint'(1) << (i + j - cutC);
    return f >> dropC;
  endfunction

  // Analytic worst-case error, counted column by column.
  function automatic longint errBound(input int aw, input int bw,
                                      input int cutC, input int dropC);
    longint s = 0;
    for (int col = 0; col < cutC; col++) begin
      int n = 0;
      for (int i = 0; i < bw; i++)
        if (col - i >= 0 && col - i < aw) n++;
      s += longint'(n) << col;
    end
    return s + (((longint'(1) << dropC) - 1) << cutC);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint ex, rf, er, bnd;
    logic [5:0] lastProd;

    // R7: reset state
    repeat (2) @(negedge clk);
    check(dValid == 1'b0, "R7 outValid in reset", dValid, 0);
    check(dProd == '0, "R7 product in reset", dProd, 0);
    rstN = 1'b1;

    // R4 table walk (registered, one-cycle latency), R9 via zero rows
    for (int v = 0; v < NVEC; v++) begin
      inValid = 1'b1; dA = TAB_A[v]; dB = TAB_B[v];
      @(negedge clk);
      check(dValid == 1'b1, "R6 outValid after request", dValid, 1);
      check(dProd == TAB_E[v], (TAB_E[v] == 0) ? "R9 zero operand" : "R4 exact floor",
            dProd, TAB_E[v]);
    end

    // R6: idle cycle holds product and clears flag
    lastProd = dProd;
    inValid = 1'b0; dA = 6'd63; dB = 6'd63;
    @(negedge clk);
    check(dValid == 1'b0, "R6 outValid after idle", dValid, 0);
    check(dProd == lastProd, "R6 hold on idle", dProd, lastProd);
    @(negedge clk);
    check(dProd == lastProd, "R6 hold second idle", dProd, lastProd);

    // Exhaustive registered unit: R5 model, R2 sign, R3 bound
    bnd = errBound(6, 6, 4, 2);
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        inValid = 1'b1; dA = 6'(a); dB = 6'(b);
        @(negedge clk);
        rf = refTrunc(a, b, 6, 6, 4, 2);
        ex = longint'(a) * longint'(b);
        er = ex - (longint'(dProd) << 6);
        if (dProd != 6'(rf)) check(1'b0, "R5 column model", dProd, rf);
        if (er < 0)          check(1'b0, "R2 error sign", er, 0);
        if (er > bnd)        check(1'b0, "R3 error bound", er, bnd);
      end
    end
    check(1'b1, "R5 exhaustive 6x6 done", 0, 0);
    inValid = 1'b0;

    // R1 and R8: exact combinational unit
    eValidIn = 1'b1;
    #1;
    check(eValid == 1'b1, "R8 outValid follows inValid", eValid, 1);
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        eA = 5'(a); eB = 5'(b);
        #1;
        if (eProd != 10'(a * b)) check(1'b0, "R1 exact product", eProd, a * b);
      end
    end
    check(1'b1, "R1 exhaustive 5x5 done", 0, 0);
    eValidIn = 1'b0;
    #1;
    check(eValid == 1'b0, "R8 outValid low", eValid, 0);
    eA = 5'd31; eB = 5'd31;
    #1;
    check(eProd == 10'd961, "R8 no clock needed", eProd, 961);

    // Skewed unit: R2, R3, R5, R9
    bnd = errBound(7, 4, 3, 1);
    for (int a = 0; a < 128; a++) begin
      for (int b = 0; b < 16; b++) begin
        sA = 7'(a); sB = 4'(b);
        #1;
        rf = refTrunc(a, b, 7, 4, 3, 1);
        ex = longint'(a) * longint'(b);
        er = ex - (longint'(sProd) << 4);
        if (sProd != 7'(rf)) check(1'b0, "R5 skew column model", sProd, rf);
        if (er < 0)          check(1'b0, "R2 skew error sign", er, 0);
        if (er > bnd)        check(1'b0, "R3 skew error bound", er, bnd);
      end
    end
    check(1'b1, "R3 exhaustive 7x4 done", 0, 0);
    sA = 7'd0; sB = 4'd15;
    #1;
    check(sProd == '0, "R9 zero multiplicand", sProd, 0);
    sA = 7'd127; sB = 4'd15;
    #1;
    rf = refTrunc(127, 15, 7, 4, 3, 1);
    check(sProd == 7'(rf), "R5 all ones", sProd, rf);
    check((1905 - (longint'(sProd) << 4)) >= 0, "R2 all ones sign",
          1905 - (longint'(sProd) << 4), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule